// File: doc/BRIEF.md
# Card Option Register with Interrupt Signalling

This block holds the 8-bit option register of a plug-in card's host interface. The host sets it with an attribute-memory write: the attribute select is low, the low chip select is low, and the memory write strobe is low, all at one fixed register address. The register's fields set four things. They can force a soft reset of the card's mailbox flags. They choose between pulse and level interrupt signalling. They decide whether an interrupt request reaches the host at all. They open or close host I/O space.

Two things follow from the register. First, the host's I/O read and write strobes are gated before they reach the mailbox bridge. When I/O space is closed, those cycles are dropped without any sign to the host. Second, an interrupt request is generated when the on-card processor raises its host-ready flag. The request is a fixed-length pulse in pulse mode, or it follows the flag in level mode.

The write strobe and the other host inputs are treated as synchronous to `clk`. A register write takes effect at the first clock edge that sees the write strobe high again after it was low.

Top module: `card_opt_ctl`

## Requirements
- R1: After reset the register reads 0x00 on `opt_q`, and `io_en`, `irq`, `mbx_flush`, `io_rd_go` and `io_wr_go` are all 0.
- R2: A write loads `host_d` into the register. It needs `host_attr_sel_n` = 0, `host_cs_lo_n` = 0 and `host_a` = `OPT_ADDR` at the clock edge where `host_mwr_n` is first seen high after being low. The new value is visible on `opt_q` right after that edge.
- R3: A write strobe with the wrong address, with `host_attr_sel_n` high, or with `host_cs_lo_n` high leaves `opt_q` unchanged.
- R4: Bit 0 opens I/O space. While bit 0 is 1 and bit 7 is 0, `io_rd_go` equals the inverse of `host_io_rd_n` and `io_wr_go` equals the inverse of `host_io_wr_n`, both gated by `host_cs_lo_n` being low. While bit 0 is 0, both outputs stay 0, whatever the strobes do.
- R5: Bit 7 is a soft reset. A write with bit 7 set makes `opt_q` read 0x80 and drives `mbx_flush` high. It forces `io_en` and `irq` to 0. Further writes with bit 7 set keep `opt_q` at 0x80. A write with bit 7 clear loads its value normally.
- R6: Level mode is bit 6 = 1 with bit 2 = 1. In this mode `irq` goes high one clock edge after `host_ready` is sampled high. It goes low one edge after `host_ready` is sampled low.
- R7: Pulse mode is bit 6 = 0 with bit 2 = 1. A rising edge of `host_ready` drives `irq` high for exactly `PULSE_LEN` (8) cycles, starting one edge after the rise is sampled. Holding `host_ready` high does not lengthen the pulse.
- R8: With bit 2 = 0, `irq` stays 0 in both modes whatever `host_ready` does.
- R9: A new rising edge of `host_ready` during a pulse restarts the pulse. `irq` then stays high for `PULSE_LEN` cycles counted from the new rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_a | input | ADDR_W | Host attribute address |
| host_attr_sel_n | input | 1 | Attribute-space select, active low |
| host_cs_lo_n | input | 1 | Low byte chip select, active low |
| host_mwr_n | input | 1 | Memory write strobe, active low |
| host_d | input | 8 | Host write data |
| host_io_rd_n | input | 1 | Host I/O read strobe, active low |
| host_io_wr_n | input | 1 | Host I/O write strobe, active low |
| host_ready | input | 1 | Processor has posted data for the host |
| opt_q | output | 8 | Current option register value |
| io_en | output | 1 | I/O space open qualifier for the mailbox bridge |
| io_rd_go | output | 1 | Qualified I/O read strobe, active high |
| io_wr_go | output | 1 | Qualified I/O write strobe, active high |
| irq | output | 1 | Interrupt request to the host, active high |
| mbx_flush | output | 1 | Holds the mailbox flags in reset |

## Verification
The assertions check several rules on every cycle. The register never changes without a decoded write strobe. The I/O strobes pass only while I/O space is open and no soft reset is pending. `irq` never rises without routing enabled. In steady level mode, `irq` equals the host-ready flag of the previous cycle. The exact eight-cycle pulse width, the restart on a second rise, the soft reset holding the register at 0x80 across later writes, and the rejected writes with a wrong address or select are shown by the bench's timed scenarios.

// File: rtl/card_opt_pkg.sv
package card_opt_pkg;

  localparam int OPT_W     = 8;
  localparam int SRST_BIT  = 7;
  localparam int LEVEL_BIT = 6;
  localparam int ROUTE_BIT = 2;
  localparam int IOEN_BIT  = 0;

  typedef struct packed {
    logic srst;
    logic level;
    logic route;
    logic ioen;
  } opt_view_t;

  // Value stored after a host write: a soft reset clears every other field.
  function automatic logic [OPT_W-1:0] opt_next(input logic [OPT_W-1:0] wdata);
    logic [OPT_W-1:0] v;
    v = wdata;
    if (wdata[SRST_BIT]) begin
      v = '0;
      v[SRST_BIT] = 1'b1;
    end
    return v;
  endfunction

  // Field view; every enable is vetoed while soft reset is held.
  function automatic opt_view_t opt_decode(input logic [OPT_W-1:0] q);
    opt_view_t v;
    v.srst  = q[SRST_BIT];
    v.level = q[LEVEL_BIT] & ~q[SRST_BIT];
    v.route = q[ROUTE_BIT] & ~q[SRST_BIT];
    v.ioen  = q[IOEN_BIT]  & ~q[SRST_BIT];
    return v;
  endfunction

endpackage

// File: rtl/card_opt_reg.sv
module card_opt_reg
  import card_opt_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] OPT_ADDR = 11'h200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADDR_W-1:0] host_a,
  input  logic             host_attr_sel_n,
  input  logic             host_cs_lo_n,
  input  logic             host_mwr_n,
  input  logic [OPT_W-1:0] host_d,
  output logic [OPT_W-1:0] opt_q,
  output logic             wr_evt
);

  logic mwr_n_d;
  logic hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mwr_n_d <= 1'b1;
    else        mwr_n_d <= host_mwr_n;
  end

  assign hit    = ~host_attr_sel_n & ~host_cs_lo_n & (host_a == OPT_ADDR);
  assign wr_evt = hit & host_mwr_n & ~mwr_n_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      opt_q <= '0;
    else if (wr_evt) opt_q <= opt_next(host_d);
  end

endmodule

// File: rtl/card_opt_irq.sv
module card_opt_irq #(
  parameter int PULSE_LEN = 8,
  localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_mode,
  input  logic route,
  input  logic host_ready,
  output logic irq
);

  logic             ready_d;
  logic             ready_rise;
  logic             lvl_q;
  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] cnt_step(
    input logic [CNT_W-1:0] cur,
    input logic             clear,
    input logic             load
  );
    if (clear)          return '0;
    else if (load)      return CNT_W'(PULSE_LEN);
    else if (cur != '0) return cur - 1'b1;
    else                return cur;
  endfunction

  assign ready_rise = host_ready & ~ready_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_d <= 1'b0;
      lvl_q   <= 1'b0;
      cnt     <= '0;
    end else begin
      ready_d <= host_ready;
      lvl_q   <= route & level_mode & host_ready;
      cnt     <= cnt_step(cnt, ~route | level_mode, ready_rise);
    end
  end

  assign irq = route & (lvl_q | (cnt != '0));

endmodule

// File: rtl/card_opt_iogate.sv
module card_opt_iogate #(
  parameter int N_STB = 2
) (
  input  logic             io_en,
  input  logic             host_cs_lo_n,
  input  logic [N_STB-1:0] stb_n,
  output logic [N_STB-1:0] go
);

  for (genvar i = 0; i < N_STB; i++) begin : g_stb
    assign go[i] = io_en & ~host_cs_lo_n & ~stb_n[i];
  end

endmodule

// File: rtl/card_opt_ctl.sv
module card_opt_ctl
  import card_opt_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] OPT_ADDR = 11'h200,
  parameter int PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_a,
  input  logic              host_attr_sel_n,
  input  logic              host_cs_lo_n,
  input  logic              host_mwr_n,
  input  logic [7:0]        host_d,
  input  logic              host_io_rd_n,
  input  logic              host_io_wr_n,
  input  logic              host_ready,
  output logic [7:0]        opt_q,
  output logic              io_en,
  output logic              io_rd_go,
  output logic              io_wr_go,
  output logic              irq,
  output logic              mbx_flush
);

  logic      opt_wr_evt;
  opt_view_t view;
  logic [1:0] go;

  card_opt_reg #(.ADDR_W(ADDR_W), .OPT_ADDR(OPT_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .host_a(host_a),
    .host_attr_sel_n(host_attr_sel_n), .host_cs_lo_n(host_cs_lo_n),
    .host_mwr_n(host_mwr_n), .host_d(host_d),
    .opt_q(opt_q), .wr_evt(opt_wr_evt)
  );

  assign view = opt_decode(opt_q);

  card_opt_irq #(.PULSE_LEN(PULSE_LEN)) u_irq (
    .clk(clk), .rst_n(rst_n), .level_mode(view.level), .route(view.route),
    .host_ready(host_ready), .irq(irq)
  );

  card_opt_iogate #(.N_STB(2)) u_gate (
    .io_en(view.ioen), .host_cs_lo_n(host_cs_lo_n),
    .stb_n({host_io_wr_n, host_io_rd_n}), .go(go)
  );

  assign io_rd_go  = go[0];
  assign io_wr_go  = go[1];
  assign io_en     = view.ioen;
  assign mbx_flush = view.srst;

endmodule

// File: rtl/card_opt_ctl_chk.sv
module card_opt_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] opt_q,
  input logic       opt_wr_evt,
  input logic       host_io_rd_n,
  input logic       host_io_wr_n,
  input logic       host_ready,
  input logic       io_rd_go,
  input logic       io_wr_go,
  input logic       irq,
  input logic       mbx_flush
);

  // R3
  opt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_wr_evt |=> $stable(opt_q));

  // R4
  io_rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd_go |-> (opt_q[0] && !opt_q[7] && !host_io_rd_n));

  // R4
  io_wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr_go |-> (opt_q[0] && !opt_q[7] && !host_io_wr_n));

  // R8
  irq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (opt_q[2] && !opt_q[7]));

  // R5
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mbx_flush |-> (opt_q[6:0] == 7'd0 && !irq && !io_rd_go && !io_wr_go));

  // R6
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_q[6] && opt_q[2] && $past(opt_q[6]) && $past(opt_q[2]))
      |-> (irq == $past(host_ready)));

endmodule

bind card_opt_ctl card_opt_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .opt_q(opt_q), .opt_wr_evt(opt_wr_evt),
  .host_io_rd_n(host_io_rd_n), .host_io_wr_n(host_io_wr_n),
  .host_ready(host_ready), .io_rd_go(io_rd_go), .io_wr_go(io_wr_go),
  .irq(irq), .mbx_flush(mbx_flush)
);

// File: tb/card_opt_ctl_bench.sv
module card_opt_ctl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 11;
  localparam logic [ADDR_W-1:0] OPT_ADDR = 11'h200;
  localparam int PULSE_LEN  = 8;
  localparam int WATCHDOG   = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] host_a = '1;
  logic              host_attr_sel_n = 1'b1;
  logic              host_cs_lo_n = 1'b1;
  logic              host_mwr_n = 1'b1;
  logic [7:0]        host_d = '0;
  logic              host_io_rd_n = 1'b1;
  logic              host_io_wr_n = 1'b1;
  logic              host_ready = 1'b0;
  logic [7:0]        opt_q;
  logic              io_en, io_rd_go, io_wr_go, irq, mbx_flush;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef enum {S_OPT, S_IOEN, S_RDGO, S_WRGO, S_IRQ, S_FLUSH} sig_e;
  typedef struct {
    sig_e        s;
    logic [7:0]  v;
    string       r;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  card_opt_ctl #(.ADDR_W(ADDR_W), .OPT_ADDR(OPT_ADDR), .PULSE_LEN(PULSE_LEN)) u_card_opt_ctl (
    .clk(clk), .rst_n(rst_n), .host_a(host_a), .host_attr_sel_n(host_attr_sel_n),
    .host_cs_lo_n(host_cs_lo_n), .host_mwr_n(host_mwr_n), .host_d(host_d),
    .host_io_rd_n(host_io_rd_n), .host_io_wr_n(host_io_wr_n), .host_ready(host_ready),
    .opt_q(opt_q), .io_en(io_en), .io_rd_go(io_rd_go), .io_wr_go(io_wr_go),
    .irq(irq), .mbx_flush(mbx_flush)
  );

  function automatic logic [7:0] pick(sig_e s);
    case (s)
      S_OPT:   return opt_q;
      S_IOEN:  return {7'd0, io_en};
      S_RDGO:  return {7'd0, io_rd_go};
      S_WRGO:  return {7'd0, io_wr_go};
      S_IRQ:   return {7'd0, irq};
      default: return {7'd0, mbx_flush};
    endcase
  endfunction

  // Monitor: pops every pending expectation at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t it;
        logic [7:0] act;
        it  = sb.pop_front();
        act = pick(it.s);
        checks++;
        if (act !== it.v) begin
          errors++;
          $display("FAIL %s %s actual=%h expected=%h", it.r, it.s.name(), act, it.v);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_sig(sig_e s, logic [7:0] v, string r);
    sb.push_back('{s: s, v: v, r: r});
  endtask

  // Write pulse; returns one step after the committing edge.
  task automatic opt_write(logic [ADDR_W-1:0] a, logic [7:0] d, logic sel_n, logic cs_n);
    host_a = a; host_d = d; host_attr_sel_n = sel_n; host_cs_lo_n = cs_n;
    host_mwr_n = 1'b0;
    tick();
    host_mwr_n = 1'b1;
    tick();
    host_a = '1; host_attr_sel_n = 1'b1; host_cs_lo_n = 1'b1;
  endtask

  task automatic pulse_window(string r);
    for (int i = 0; i < PULSE_LEN; i++) begin
      expect_sig(S_IRQ, 8'd1, r);
      tick();
    end
    expect_sig(S_IRQ, 8'd0, r);
    tick();
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    expect_sig(S_OPT, 8'h00, "R1"); expect_sig(S_IOEN, 8'd0, "R1");
    expect_sig(S_IRQ, 8'd0, "R1");  expect_sig(S_FLUSH, 8'd0, "R1");
    tick();
    host_cs_lo_n = 1'b0; host_io_rd_n = 1'b0;
    expect_sig(S_RDGO, 8'd0, "R1");
    tick();
    host_cs_lo_n = 1'b1; host_io_rd_n = 1'b1;

    // R3 rejected writes
    opt_write(OPT_ADDR + 11'd1, 8'h05, 1'b0, 1'b0);
    expect_sig(S_OPT, 8'h00, "R3 address");
    tick();
    opt_write(OPT_ADDR, 8'h05, 1'b1, 1'b0);
    expect_sig(S_OPT, 8'h00, "R3 select");
    tick();
    opt_write(OPT_ADDR, 8'h05, 1'b0, 1'b1);
    expect_sig(S_OPT, 8'h00, "R3 chip select");
    tick();

    // R2 accepted write: pulse mode, routed, I/O open
    opt_write(OPT_ADDR, 8'h05, 1'b0, 1'b0);
    expect_sig(S_OPT, 8'h05, "R2"); expect_sig(S_IOEN, 8'd1, "R2");
    tick();

    // R4 strobes pass while open
    host_cs_lo_n = 1'b0; host_io_rd_n = 1'b0;
    expect_sig(S_RDGO, 8'd1, "R4 read open"); expect_sig(S_WRGO, 8'd0, "R4 read open");
    tick();
    host_io_rd_n = 1'b1; host_io_wr_n = 1'b0;
    expect_sig(S_RDGO, 8'd0, "R4 write open"); expect_sig(S_WRGO, 8'd1, "R4 write open");
    tick();
    host_io_wr_n = 1'b1; host_cs_lo_n = 1'b1;
    tick();

    // R7 single pulse, flag held high afterwards
    host_ready = 1'b1;
    expect_sig(S_IRQ, 8'd0, "R7 before edge");
    tick();
    pulse_window("R7");
    expect_sig(S_IRQ, 8'd0, "R7 held flag");
    tick();
    host_ready = 1'b0;
    repeat (2) tick();

    // R9 retrigger during a pulse
    host_ready = 1'b1;
    tick();
    host_ready = 1'b0;
    tick();
    host_ready = 1'b1;
    tick();
    pulse_window("R9");
    host_ready = 1'b0;
    repeat (2) tick();

    // R8 no routing, pulse then level mode
    opt_write(OPT_ADDR, 8'h01, 1'b0, 1'b0);
    host_ready = 1'b1;
    repeat (3) begin
      tick();
      expect_sig(S_IRQ, 8'd0, "R8 pulse unrouted");
    end
    tick();
    host_ready = 1'b0;
    tick();
    opt_write(OPT_ADDR, 8'h41, 1'b0, 1'b0);
    host_ready = 1'b1;
    repeat (3) begin
      tick();
      expect_sig(S_IRQ, 8'd0, "R8 level unrouted");
    end
    tick();
    host_ready = 1'b0;
    tick();

    // R4 closed I/O space, R6 level mode
    opt_write(OPT_ADDR, 8'h44, 1'b0, 1'b0);
    expect_sig(S_OPT, 8'h44, "R2"); expect_sig(S_IOEN, 8'd0, "R4");
    host_cs_lo_n = 1'b0; host_io_rd_n = 1'b0; host_io_wr_n = 1'b0;
    expect_sig(S_RDGO, 8'd0, "R4 closed"); expect_sig(S_WRGO, 8'd0, "R4 closed");
    tick();
    host_cs_lo_n = 1'b1; host_io_rd_n = 1'b1; host_io_wr_n = 1'b1;
    host_ready = 1'b1;
    expect_sig(S_IRQ, 8'd0, "R6 before edge");
    tick();
    repeat (12) begin
      expect_sig(S_IRQ, 8'd1, "R6 held");
      tick();
    end
    host_ready = 1'b0;
    expect_sig(S_IRQ, 8'd1, "R6 drop lag");
    tick();
    expect_sig(S_IRQ, 8'd0, "R6 released");
    tick();

    // R5 soft reset with the flag high in level mode
    host_ready = 1'b1;
    repeat (2) tick();
    expect_sig(S_IRQ, 8'd1, "R6 before reset");
    tick();
    opt_write(OPT_ADDR, 8'hC5, 1'b0, 1'b0);
    expect_sig(S_OPT, 8'h80, "R5"); expect_sig(S_FLUSH, 8'd1, "R5");
    expect_sig(S_IRQ, 8'd0, "R5"); expect_sig(S_IOEN, 8'd0, "R5");
    tick();
    opt_write(OPT_ADDR, 8'h85, 1'b0, 1'b0);
    expect_sig(S_OPT, 8'h80, "R5 held"); expect_sig(S_IRQ, 8'd0, "R5 held");
    tick();
    opt_write(OPT_ADDR, 8'h44, 1'b0, 1'b0);
    expect_sig(S_OPT, 8'h44, "R5 release"); expect_sig(S_FLUSH, 8'd0, "R5 release");
    expect_sig(S_IRQ, 8'd0, "R6 after release");
    tick();
    expect_sig(S_IRQ, 8'd1, "R6 after release");
    tick();
    host_ready = 1'b0;
    repeat (3) tick();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule